// File: doc/BRIEF.md
# Word-Serial Radix-4 Booth Multiplier

This block forms the full unsigned product of two N-bit operands. The multiplicand is latched whole and applied in parallel. The multiplier is consumed one W-bit word per cycle, least significant word first. The multiplier may be supplied in redundant form, as a sum vector and a carry vector. Each word is converted to binary on the way in, with the carry between words held in a flip-flop. The binary word is radix-4 Booth recoded into W/2 signed digits. Each digit selects a row that a chain of carry-save adders folds into a redundant running sum. That running sum is shifted right by W after every step.

The bits that drop off the bottom of the running sum are complete words of the low product half. They are resolved to binary and shifted into a low-result register from the top, so after N/W steps that register holds the low half in order. A final correction step makes the signed Booth digits yield an exact unsigned product. When it ends, the upper product half is left as a sum/carry pair. That pair can be fed straight back as the redundant multiplier of the next operation.

The running sum can start from a supplied N-bit value instead of zero, which adds that value to the product. Writes into the low-result register can be suppressed for a whole operation.

Top module: `wordser_booth_mul`

## Requirements
- R1: After reset, `busy_o` is 0 and `low_o`, `high_sum_o` and `high_carry_o` are all zero.
- R2: A `start_i` seen high at a clock edge while `busy_o` is 0 latches all operands and flags. `busy_o` is then 1 for exactly N/W+1 cycles and returns to 0.
- R3: With the multiplier value X = (`mplr_sum_i` + `mplr_carry_i`) mod 2^N, the multiplicand M and the preload disabled, `low_o` equals (M·X) mod 2^N once `busy_o` has fallen.
- R4: Once `busy_o` has fallen, (`high_sum_o` + `high_carry_o`) mod 2^N equals bits 2N-1..N of M·X + L. L is the preload value when the preload is enabled and 0 when it is not.
- R5: With `init_en_i` high at start, `init_i` is added to the product. With `init_en_i` low, the value on `init_i` has no effect on `low_o` or the high pair.
- R6: With `low_hold_i` high at start, `low_o` keeps its prior value for the whole operation.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored, and so are changes of the operand inputs during an operation. The running operation's results are unaffected.
- R8: On step cycle k (k = 0..N/W-1), product word k (bits kW+W-1..kW) enters `low_o` at bits N-1..N-W while the previous contents move down by W bits. The step cycle is the (k+1)-th cycle after the start edge.
- R9: Boundary operands give exact results: a zero multiplicand, an all-ones multiplier (including both redundant halves all ones) and an all-ones multiplicand.
- R10: The high sum/carry pair of a finished operation, applied unchanged as the multiplier sum and carry of the next operation, is used as the value (pair sum) mod 2^N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| mcand_i | input | N | Multiplicand, latched at start |
| mplr_sum_i | input | N | Multiplier sum vector, latched at start |
| mplr_carry_i | input | N | Multiplier carry vector, latched at start |
| init_i | input | N | Value the running sum starts from |
| init_en_i | input | 1 | Use `init_i` as the starting sum (else zero) |
| low_hold_i | input | 1 | Suppress writes into the low-result register |
| busy_o | output | 1 | Operation in progress |
| low_o | output | N | Low-result register |
| high_sum_o | output | N | High product half, sum vector |
| high_carry_o | output | N | High product half, carry vector |

## Verification
The bench builds the block with N = 64 and W = 16, so one operation takes four word steps and the correction step. Every Booth triple that crosses a word edge is exercised, and so is the carry between redundant multiplier words. Products reach 128 bits, so sign handling and the bias correction are tested over their full span, and boundary patterns are cheap to run. A behavioural model predicts the low register word by word and the busy flag on every clock. The high pair is checked against an integer product at the end of each operation.

// File: rtl/wsm_pkg.sv
package wsm_pkg;

    // One radix-4 Booth digit: sign and magnitude (0, 1 or 2).
    typedef struct packed {
        logic       neg;
        logic [1:0] mag;
    } booth_dig_t;

    // Triple is {upper bit, middle bit, bit below}.
    function automatic booth_dig_t recode(input logic [2:0] t);
        booth_dig_t d;
        d.neg = t[2] & ~(t[1] & t[0]);
        case (t)
            3'b000, 3'b111: d.mag = 2'd0;
            3'b011, 3'b100: d.mag = 2'd2;
            default:        d.mag = 2'd1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/wsm_word_add.sv
module wsm_word_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    always_comb begin
        {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    end
endmodule

// File: rtl/wsm_booth_rows.sv
module wsm_booth_rows #(
    parameter int N = 64,
    parameter int W = 16,
    parameter int A = N + W + 4
) (
    input  logic [N-1:0] mcand_i,
    input  logic [W-1:0] word_i,
    input  logic         prev_i,
    input  logic         kill_i,
    output logic [A-1:0] rows_o [W/2+1]
);
    localparam int D = W / 2;

    logic [W:0]   ext;
    logic [W-1:0] hot;

    assign ext = {word_i, prev_i};

    // Each row is biased by 2^(N+1) so that it is never negative:
    // positive digit -> {1, |d|M}, negative digit -> {0, ~|d|M} plus a hot one.
    for (genvar j = 0; j < D; j++) begin : g_dig
        wsm_pkg::booth_dig_t dig;
        logic [N:0]   mag_v;
        logic [N+1:0] row_v;

        assign dig   = wsm_pkg::recode(ext[2*j +: 3]);
        assign mag_v = (dig.mag == 2'd2) ? {mcand_i, 1'b0} :
                       (dig.mag == 2'd1) ? {1'b0, mcand_i} : '0;
        assign row_v = dig.neg ? {1'b0, ~mag_v} : {1'b1, mag_v};
        assign rows_o[j]    = kill_i ? '0 : (A'(row_v) << (2*j));
        assign hot[2*j]     = dig.neg & ~kill_i;
        assign hot[2*j+1]   = 1'b0;
    end

    assign rows_o[D] = A'(hot);
endmodule

// File: rtl/wsm_csa_chain.sv
module wsm_csa_chain #(
    parameter int A = 84,
    parameter int R = 12
) (
    input  logic [A-1:0] s_i,
    input  logic [A-1:0] c_i,
    input  logic [A-1:0] rows_i [R],
    output logic [A-1:0] s_o,
    output logic [A-1:0] c_o
);
    // Linear array of 3:2 compressors, one per row.
    always_comb begin
        logic [A-1:0] s, c, t;
        s = s_i;
        c = c_i;
        for (int r = 0; r < R; r++) begin
            t = s ^ c ^ rows_i[r];
            c = ((s & c) | (s & rows_i[r]) | (c & rows_i[r])) << 1;
            s = t;
        end
        s_o = s;
        c_o = c;
    end
endmodule

// File: rtl/wordser_booth_mul.sv
module wordser_booth_mul #(
    parameter int N = 64,
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [N-1:0] mcand_i,
    input  logic [N-1:0] mplr_sum_i,
    input  logic [N-1:0] mplr_carry_i,
    input  logic [N-1:0] init_i,
    input  logic         init_en_i,
    input  logic         low_hold_i,
    output logic         busy_o,
    output logic [N-1:0] low_o,
    output logic [N-1:0] high_sum_o,
    output logic [N-1:0] high_carry_o
);
    localparam int NW = N / W;
    localparam int D  = W / 2;
    localparam int A  = N + W + 4;
    localparam int R  = D + 4;
    localparam int SW = $clog2(NW + 1);

    // Constant that cancels the row biases and adds 2^(2N), which
    // falls above the kept high half.
    function automatic logic [2*N:0] fold_const();
        logic [2*N:0] step_b, tot;
        step_b = '0;
        for (int j = 0; j < D; j++) step_b += (2*N+1)'(1) << (N + 1 + 2*j);
        tot = '0;
        for (int k = 0; k < NW; k++) tot += step_b << (k * W);
        return ((2*N+1)'(1) << (2*N)) - tot;
    endfunction
    localparam logic [2*N:0] FOLD = fold_const();

    typedef struct packed {
        logic          busy;
        logic          hold;
        logic [SW-1:0] step;
        logic [N-1:0]  mcand;
        logic [N-1:0]  xs;
        logic [N-1:0]  xc;
        logic [N-1:0]  low;
        logic          xcy;
        logic          prev;
        logic          lcy;
        logic [A-1:0]  fs;
        logic [A-1:0]  fc;
    } st_t;

    st_t st_d, st_q;

    logic          corr;
    logic [W-1:0]  xword, lword;
    logic          xco, lco;
    logic [A-1:0]  brows    [D+1];
    logic [A-1:0]  rows_all [R];
    logic [A-1:0]  ns, nc;
    logic [2*N:0]  fold_sh;

    assign corr = (st_q.step == SW'(NW));

    wsm_word_add #(.W(W)) u_xconv (
        .a_i(st_q.xs[W-1:0]), .b_i(st_q.xc[W-1:0]), .cin_i(st_q.xcy),
        .sum_o(xword), .cout_o(xco)
    );

    wsm_booth_rows #(.N(N), .W(W), .A(A)) u_rows (
        .mcand_i(st_q.mcand), .word_i(xword), .prev_i(st_q.prev),
        .kill_i(corr), .rows_o(brows)
    );

    always_comb begin
        fold_sh = FOLD >> (W * int'(st_q.step));
        for (int j = 0; j <= D; j++) rows_all[j] = brows[j];
        rows_all[D+1] = corr ? A'(FOLD[2*N-1:N]) : A'(fold_sh[W-1:0]);
        rows_all[D+2] = (corr && st_q.prev) ? A'(st_q.mcand) : '0;
        rows_all[D+3] = corr ? A'(st_q.lcy) : '0;
    end

    wsm_csa_chain #(.A(A), .R(R)) u_csa (
        .s_i(st_q.fs), .c_i(st_q.fc), .rows_i(rows_all), .s_o(ns), .c_o(nc)
    );

    wsm_word_add #(.W(W)) u_lconv (
        .a_i(ns[W-1:0]), .b_i(nc[W-1:0]), .cin_i(st_q.lcy),
        .sum_o(lword), .cout_o(lco)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.hold  = low_hold_i;
                st_d.step  = '0;
                st_d.mcand = mcand_i;
                st_d.xs    = mplr_sum_i;
                st_d.xc    = mplr_carry_i;
                st_d.xcy   = 1'b0;
                st_d.prev  = 1'b0;
                st_d.lcy   = 1'b0;
                st_d.fs    = init_en_i ? A'(init_i) : '0;
                st_d.fc    = '0;
            end
        end else if (!corr) begin
            st_d.xs   = st_q.xs >> W;
            st_d.xc   = st_q.xc >> W;
            st_d.xcy  = xco;
            st_d.prev = xword[W-1];
            st_d.fs   = ns >> W;
            st_d.fc   = nc >> W;
            st_d.lcy  = lco;
            if (!st_q.hold) st_d.low = {lword, st_q.low[N-1:W]};
            st_d.step = st_q.step + 1'b1;
        end else begin
            st_d.fs   = ns;
            st_d.fc   = nc;
            st_d.busy = 1'b0;
            st_d.step = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o       = st_q.busy;
    assign low_o        = st_q.low;
    assign high_sum_o   = st_q.fs[N-1:0];
    assign high_carry_o = st_q.fc[N-1:0];

    // R2: an accepted start raises busy on the next edge
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && start_i) |=> st_q.busy);

    // R2: the correction step is the last busy cycle
    p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && corr) |=> !st_q.busy);

    // R2: word steps never end an operation early
    p_busy_cont_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !corr) |=> st_q.busy);

    // R6: a held low register does not move
    p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.hold) |=> $stable(st_q.low));

    // R7: operands are frozen while busy
    p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start_i) |=> $stable(st_q.mcand));
endmodule

// File: tb/wordser_booth_mul_tb_top.sv
module wordser_booth_mul_tb_top;
    localparam int N  = 64;
    localparam int W  = 16;
    localparam int NW = N / W;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [N-1:0] mcand, xs, xc, init;
    logic         init_en, hold;
    logic         busy;
    logic [N-1:0] low, hsum, hcar;

    int n_tests = 0;
    int n_fail  = 0;

    logic           m_busy = 1'b0;
    int             m_step = 0;
    logic           m_hold = 1'b0;
    logic [N-1:0]   m_low  = '0;
    logic [2*N-1:0] m_p    = '0;
    logic           m_done = 1'b0;

    always #10 clk = ~clk;

    wordser_booth_mul #(.N(N), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mcand_i(mcand),
        .mplr_sum_i(xs), .mplr_carry_i(xc), .init_i(init),
        .init_en_i(init_en), .low_hold_i(hold), .busy_o(busy),
        .low_o(low), .high_sum_o(hsum), .high_carry_o(hcar)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock: update the reference model at the edge, compare at negedge.
    task automatic cycle();
        logic [N-1:0] x;
        @(posedge clk);
        if (!m_busy) begin
            if (start) begin
                x      = xs + xc;
                m_busy = 1'b1;
                m_step = 0;
                m_hold = hold;
                m_p    = (2*N)'(mcand) * (2*N)'(x) + (init_en ? (2*N)'(init) : '0);
            end
        end else if (m_step < NW) begin
            if (!m_hold) m_low = {m_p[m_step*W +: W], m_low[N-1:W]};
            m_step++;
        end else begin
            m_busy = 1'b0;
            m_done = 1'b1;
        end
        @(negedge clk);
        check(busy == m_busy, "R2", "busy", N'(busy), N'(m_busy));
        check(low == m_low, "R8", "low word stream", low, m_low);
        if (m_done) begin
            check(N'(hsum + hcar) == m_p[2*N-1:N], "R4", "high pair", N'(hsum + hcar), m_p[2*N-1:N]);
            m_done = 1'b0;
        end
    endtask

    task automatic do_mul(input logic [N-1:0] m, input logic [N-1:0] s,
                          input logic [N-1:0] c, input logic [N-1:0] l,
                          input logic ien, input logic hld, input bit poke,
                          input string req);
        logic [N-1:0]   low_before, xv;
        logic [2*N-1:0] p;
        low_before = low;
        xv = s + c;
        p  = (2*N)'(m) * (2*N)'(xv) + (ien ? (2*N)'(l) : '0);
        mcand = m; xs = s; xc = c; init = l; init_en = ien; hold = hld;
        start = 1'b1;
        cycle();
        start = 1'b0;
        if (poke) begin
            start = 1'b1; mcand = ~m; xs = ~s; init_en = ~ien; hold = ~hld;
            cycle();
            start = 1'b0;
        end
        while (m_busy) cycle();
        check(low == (hld ? low_before : p[N-1:0]), req, "final low", low,
              hld ? low_before : p[N-1:0]);
        check(N'(hsum + hcar) == p[2*N-1:N], req, "final high", N'(hsum + hcar), p[2*N-1:N]);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] ones;
        ones  = '1;
        rst_n = 1'b0; start = 1'b0; mcand = '0; xs = '0; xc = '0;
        init  = '0; init_en = 1'b0; hold = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1", "busy after reset", N'(busy), '0);
        check(low == '0, "R1", "low after reset", low, '0);
        check(hsum == '0, "R1", "high sum after reset", hsum, '0);
        check(hcar == '0, "R1", "high carry after reset", hcar, '0);

        // R3 basic products, binary and redundant multiplier
        do_mul(64'd3, 64'd5, 64'd0, '0, 1'b0, 1'b0, 1'b0, "R3");
        do_mul(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'd0, '0, 1'b0, 1'b0, 1'b0, "R3");
        do_mul(64'h8000_0000_0000_8001, 64'h7FFF_0000_8000_FFFF, 64'h0001_FFFF_8000_0001, '0, 1'b0, 1'b0, 1'b0, "R3");

        // R9 boundaries
        do_mul('0, ones, ones, '0, 1'b0, 1'b0, 1'b0, "R9");
        do_mul(ones, ones, '0, '0, 1'b0, 1'b0, 1'b0, "R9");
        do_mul(ones, ones, ones, '0, 1'b0, 1'b0, 1'b0, "R9");
        do_mul(64'h8000_0000_0000_0000, 64'h8000_8000_8000_8000, '0, '0, 1'b0, 1'b0, 1'b0, "R9");

        // R5 preload used and ignored
        do_mul(ones, ones, '0, ones, 1'b1, 1'b0, 1'b0, "R5");
        do_mul(64'h1357, 64'h2468, '0, 64'hDEAD_BEEF_0000_1111, 1'b1, 1'b0, 1'b0, "R5");
        do_mul(64'h1357, 64'h2468, '0, 64'hDEAD_BEEF_0000_1111, 1'b0, 1'b0, 1'b0, "R5");

        // R6 low register held
        do_mul(64'hAAAA_5555_AAAA_5555, 64'h0F0F_F0F0_0F0F_F0F0, 64'h1111, '0, 1'b0, 1'b1, 1'b0, "R6");

        // R7 start and operand changes during an operation
        do_mul(64'h0000_0001_0000_0003, 64'h1234_5678_9ABC_DEF0, 64'h0F, '0, 1'b0, 1'b0, 1'b1, "R7");

        // R10 chaining the redundant high half as the next multiplier
        do_mul(64'hFFFF_0000_FFFF_0000, 64'hC0DE_CAFE_F00D_BEEF, 64'h3333_3333_3333_3333, '0, 1'b0, 1'b0, 1'b0, "R10");
        do_mul(64'h9E37_79B9_7F4A_7C15, hsum, hcar, '0, 1'b0, 1'b0, 1'b0, "R10");
        do_mul(64'h0000_0000_0000_0007, hsum, hcar, 64'h5, 1'b1, 1'b0, 1'b0, "R10");

        // R3 patterned sweep
        for (int i = 0; i < 12; i++) begin
            do_mul({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                   {$urandom, $urandom}, 1'(i % 2), 1'b0, 1'b0, "R3");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule